// File: doc/BRIEF.md
# TDM Time-Slot Assigner

This block distributes the bits of a serial time-division-multiplexed frame among up to seven internal serial channels, and collects their transmit bits back onto one line. A frame begins with a sync pulse. From the next bit onward, a sequencer walks a small programmable table. Each table entry claims a run of consecutive bits for one channel, or for no channel. Each entry also carries a strobe pattern and can end the frame.

Receive and transmit each have their own table, sequencer and sync input. A link mode lets the receive sync start both directions, so one bus can serve both. A grant input is captured whenever the transmit sync is seen. It is held until the next sync and is presented to one channel, selected by a parameter, which is the channel that carries the D bits of the frame. All timing runs from one bit clock. Sync and grant are sampled on its falling edge. Transmit data and every slot boundary change on its rising edge.

Top module: `tdm_slot_router`

## Requirements
- R1: When a sync input is high at a falling clock edge, the bit period that starts at the next rising edge is bit 0 of the frame, and it uses table entry 0.
- R2: An entry with field `bytes`=0 spans cnt+1 bit periods. An entry with `bytes`=1 spans (cnt+1)*8 bit periods. The entries follow one another in address order.
- R3: The receive bit of a bit period that belongs to channel c (c = 1..7) appears on `rx_bit_o` during the following bit period. In that same period `rx_vld_o[c-1]` is high and no other valid bit is high.
- R4: During a transmit bit that belongs to channel c, `tx_oe_o` is 1, `tx_take_o` is one-hot at bit c-1, and `tx_o` equals `tx_bit_i[c-1]`.
- R5: A bit whose entry has channel select 0 is not routed. In that bit `tx_oe_o`, `tx_o` and `tx_take_o` are 0, and no `rx_vld_o` bit follows it.
- R6: After the last bit of an entry whose `last` flag is 1, or of entry DEPTH-1, the direction is idle until its next sync. While idle, the transmit side keeps `tx_oe_o` low and the receive side raises no valid bit.
- R7: `rx_strb_o` and `tx_strb_o` equal the strobe field of the entry that is active in that direction. They are 0 while that direction is idle.
- R8: `grant_i` is sampled at each falling edge at which the transmit sync is high. The sampled value is held on `gnt_o[GNT_CHAN-1]` until the next such edge. All other `gnt_o` bits are 0.
- R9: When `sync_link_i`=1, `rsync_i` starts both directions and `tsync_i` has no effect. When `sync_link_i`=0, each direction uses its own sync.
- R10: A write with `tbl_we_i`=1 stores `tbl_wdata_i` at `tbl_addr_i` in the transmit table if `tbl_tx_i`=1, and otherwise in the receive table. The entry fields are laid out as follows: [2:0] channel select, [6:3] cnt, [7] bytes, [11:8] strobe, [12] last.
- R11: While `rst_ni` is low, both directions are idle, the tables are cleared, and `tx_oe_o`, `tx_o`, `rx_vld_o`, `rx_bit_o`, the strobes and `gnt_o` are all 0.
- R12: A sync that arrives in the middle of a frame restarts that direction at entry 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsync_i | input | 1 | Receive frame sync |
| tsync_i | input | 1 | Transmit frame sync |
| sync_link_i | input | 1 | 1: receive sync starts both directions |
| grant_i | input | 1 | Grant line, sampled with the transmit sync |
| rx_i | input | 1 | Serial receive data |
| tx_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit output enable (0 = high impedance) |
| rx_bit_o | output | 1 | Received bit forwarded to channels |
| rx_vld_o | output | 7 | Per-channel receive bit valid |
| tx_bit_i | input | 7 | Per-channel transmit bit |
| tx_take_o | output | 7 | Per-channel transmit bit consumed |
| rx_strb_o | output | 4 | Strobes of the active receive entry |
| tx_strb_o | output | 4 | Strobes of the active transmit entry |
| gnt_o | output | 7 | Grant indication, on the D channel's bit only |
| tbl_we_i | input | 1 | Table write enable |
| tbl_tx_i | input | 1 | Table select: 1 transmit, 0 receive |
| tbl_addr_i | input | 4 | Table entry address |
| tbl_wdata_i | input | 13 | Table entry data |

## Verification
A sync that is seen at the falling edge of bit period s makes period s+1 frame bit 0. The transmit outputs and both strobe buses are combinational from that period's state. The bench therefore checks them in the same period as the bit, shortly after the falling edge. Received bits pass through one register, so the bench checks the `rx_vld_o` and `rx_bit_o` for frame bit j during period j+1. The grant appears on `gnt_o` from the period that follows the sync sample, and the bench checks it on the first data bit. Every input changes just after a rising edge, and every output is sampled just after a falling edge.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int unsigned CSEL_W = 3;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned SSEL_W = 4;
  localparam int unsigned ENT_W  = CSEL_W + CNT_W + 1 + SSEL_W + 1;

  typedef struct packed {
    logic              last;
    logic [SSEL_W-1:0] ssel;
    logic              bytes;
    logic [CNT_W-1:0]  cnt;
    logic [CSEL_W-1:0] csel;
  } entry_t;
endpackage

// File: rtl/tsa_table.sv
module tsa_table
  import tsa_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output entry_t           rdata_o
);
  entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= entry_t'(wdata_i);
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tsa_seq.sv
module tsa_seq
  import tsa_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  entry_t        ent_i,
  output logic [AW-1:0] idx_o,
  output logic          act_o
);
  localparam int unsigned LEN_W = CNT_W + 3;

  logic [LEN_W-1:0] pos_q, len_m1;
  logic             slot_end;

  // byte mode: (cnt+1)*8-1 = cnt*8+7
  assign len_m1   = ent_i.bytes ? {ent_i.cnt, 3'b111} : LEN_W'(ent_i.cnt);
  assign slot_end = act_o && (pos_q == len_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      idx_o <= '0;
      pos_q <= '0;
    end else if (start_i) begin
      act_o <= 1'b1;
      idx_o <= '0;
      pos_q <= '0;
    end else if (act_o) begin
      if (slot_end) begin
        pos_q <= '0;
        if (ent_i.last || idx_o == AW'(DEPTH - 1)) act_o <= 1'b0;
        else idx_o <= idx_o + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  a_r1_start_entry0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (act_o && idx_o == '0));
  a_r6_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_o && !start_i) |=> !act_o);
  a_r2_hold_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && !start_i && !slot_end) |=> (act_o && $stable(idx_o)));
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tsa_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned GNT_CHAN = 3,
  localparam int unsigned AW  = $clog2(DEPTH),
  localparam int unsigned NCH = (2 ** CSEL_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsync_i,
  input  logic              tsync_i,
  input  logic              sync_link_i,
  input  logic              grant_i,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              tx_oe_o,
  output logic              rx_bit_o,
  output logic [NCH-1:0]    rx_vld_o,
  input  logic [NCH-1:0]    tx_bit_i,
  output logic [NCH-1:0]    tx_take_o,
  output logic [SSEL_W-1:0] rx_strb_o,
  output logic [SSEL_W-1:0] tx_strb_o,
  output logic [NCH-1:0]    gnt_o,
  input  logic              tbl_we_i,
  input  logic              tbl_tx_i,
  input  logic [AW-1:0]     tbl_addr_i,
  input  logic [ENT_W-1:0]  tbl_wdata_i
);
  logic rs_q, ts_q, gnt_q, ts_eff;
  logic [AW-1:0] rx_idx, tx_idx;
  logic rx_act, tx_act;
  entry_t rx_ent, tx_ent;
  logic [NCH-1:0] rx_hit;

  assign ts_eff = sync_link_i ? rsync_i : tsync_i;

  // sync and grant captured on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_q  <= 1'b0;
      ts_q  <= 1'b0;
      gnt_q <= 1'b0;
    end else begin
      rs_q <= rsync_i;
      ts_q <= ts_eff;
      if (ts_eff) gnt_q <= grant_i;
    end
  end

  tsa_table #(.DEPTH(DEPTH)) u_rx_tbl (
    .clk_i, .rst_ni,
    .we_i(tbl_we_i && !tbl_tx_i), .waddr_i(tbl_addr_i), .wdata_i(tbl_wdata_i),
    .raddr_i(rx_idx), .rdata_o(rx_ent)
  );
  tsa_table #(.DEPTH(DEPTH)) u_tx_tbl (
    .clk_i, .rst_ni,
    .we_i(tbl_we_i && tbl_tx_i), .waddr_i(tbl_addr_i), .wdata_i(tbl_wdata_i),
    .raddr_i(tx_idx), .rdata_o(tx_ent)
  );

  tsa_seq #(.DEPTH(DEPTH)) u_rx_seq (
    .clk_i, .rst_ni, .start_i(rs_q), .ent_i(rx_ent), .idx_o(rx_idx), .act_o(rx_act)
  );
  tsa_seq #(.DEPTH(DEPTH)) u_tx_seq (
    .clk_i, .rst_ni, .start_i(ts_q), .ent_i(tx_ent), .idx_o(tx_idx), .act_o(tx_act)
  );

  assign tx_oe_o = tx_act && (tx_ent.csel != '0);

  for (genvar c = 1; c <= int'(NCH); c++) begin : g_chan
    assign tx_take_o[c-1] = tx_oe_o && (tx_ent.csel == CSEL_W'(c));
    assign rx_hit[c-1]    = rx_act && (rx_ent.csel == CSEL_W'(c));
  end

  assign tx_o = |(tx_take_o & tx_bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_vld_o <= '0;
      rx_bit_o <= 1'b0;
    end else begin
      rx_vld_o <= rx_hit;
      rx_bit_o <= (|rx_hit) ? rx_i : 1'b0;
    end
  end

  assign rx_strb_o = rx_act ? rx_ent.ssel : '0;
  assign tx_strb_o = tx_act ? tx_ent.ssel : '0;
  assign gnt_o     = NCH'(gnt_q) << (GNT_CHAN - 1);

  a_r3_rx_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_vld_o));
  a_r4_take_when_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_o |-> ($countones(tx_take_o) == 1));
  a_r5_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_oe_o |-> (!tx_o && tx_take_o == '0));
  a_r6_idle_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_act |-> (tx_strb_o == '0 && !tx_oe_o));
endmodule

// File: tb/sim_tdm_slot_router.sv
module sim_tdm_slot_router;
  localparam int P = 10;
  localparam int NBIT = 19;
  // per frame bit: {strobe[3:0], channel[2:0]}
  localparam logic [6:0] VEC [NBIT] = '{
    7'h02, 7'h02, 7'h02, 7'h02, 7'h02, 7'h02, 7'h02, 7'h02,
    7'h03, 7'h00,
    7'h06, 7'h06, 7'h06, 7'h06, 7'h06, 7'h06, 7'h06, 7'h06,
    7'h0B
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rsync_i = 0, tsync_i = 0, sync_link_i = 1, grant_i = 0, rx_i = 0;
  logic tx_o, tx_oe_o, rx_bit_o;
  logic [6:0] rx_vld_o, tx_take_o, gnt_o, tx_bit_i = '0;
  logic [3:0] rx_strb_o, tx_strb_o;
  logic tbl_we_i = 0, tbl_tx_i = 0;
  logic [3:0] tbl_addr_i = '0;
  logic [12:0] tbl_wdata_i = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(P/2) clk = ~clk;

  tdm_slot_router u0 (
    .clk_i(clk), .rst_ni, .rsync_i, .tsync_i, .sync_link_i, .grant_i, .rx_i,
    .tx_o, .tx_oe_o, .rx_bit_o, .rx_vld_o, .tx_bit_i, .tx_take_o,
    .rx_strb_o, .tx_strb_o, .gnt_o, .tbl_we_i, .tbl_tx_i, .tbl_addr_i, .tbl_wdata_i
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic smp();
    @(negedge clk); #1;
  endtask

  function automatic logic [12:0] mk(logic last, logic [3:0] ssel, logic bytes,
                                     logic [3:0] cnt, logic [2:0] csel);
    return {last, ssel, bytes, cnt, csel};
  endfunction

  task automatic wr(input logic tx, input logic [3:0] a, input logic [12:0] d);
    tick();
    tbl_we_i = 1; tbl_tx_i = tx; tbl_addr_i = a; tbl_wdata_i = d;
    tick();
    tbl_we_i = 0;
  endtask

  function automatic logic rpat(int j);
    return ((j % 3) == 1) ^ (j > 9);
  endfunction

  function automatic logic [6:0] tpat(int j);
    return 7'(j * 29 + 11);
  endfunction

  function automatic logic [6:0] oh(logic [2:0] ch);
    return (ch == 0) ? 7'd0 : 7'(1 << (ch - 1));
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(P * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R11 reset state
    #(P * 2 + 2);
    chk("R11 oe", tx_oe_o, 0);
    chk("R11 tx", tx_o, 0);
    chk("R11 vld", rx_vld_o, 0);
    chk("R11 rxbit", rx_bit_o, 0);
    chk("R11 strb", {rx_strb_o, tx_strb_o}, 0);
    chk("R11 gnt", gnt_o, 0);
    tick(); rst_ni = 1;

    // R10 program both tables with the example frame
    for (int t = 0; t < 2; t++) begin
      wr(t[0], 4'd0, mk(0, 4'd0, 1, 4'd0, 3'd2));
      wr(t[0], 4'd1, mk(0, 4'd0, 0, 4'd0, 3'd3));
      wr(t[0], 4'd2, mk(0, 4'd0, 0, 4'd0, 3'd0));
      wr(t[0], 4'd3, mk(0, 4'd0, 1, 4'd0, 3'd6));
      wr(t[0], 4'd4, mk(1, 4'd1, 0, 4'd0, 3'd3));
    end

    // example frame, linked sync, grant=1 (R1 R3 R4 R5 R7 R8 R9 R10)
    tick(); sync_link_i = 1; rsync_i = 1; grant_i = 1;
    smp(); chk("R1 idle before data", tx_oe_o, 0);
    for (int j = 0; j < NBIT; j++) begin
      tick(); rsync_i = 0; grant_i = 0; rx_i = rpat(j); tx_bit_i = tpat(j);
      smp();
      chk("R4 oe", tx_oe_o, VEC[j][2:0] != 0);
      chk("R4 take", tx_take_o, oh(VEC[j][2:0]));
      chk("R4 tx data", tx_o, (VEC[j][2:0] != 0) ? tpat(j)[VEC[j][2:0] - 1] : 1'b0);
      chk("R7 tx strobe", tx_strb_o, VEC[j][6:3]);
      chk("R7 rx strobe", rx_strb_o, VEC[j][6:3]);
      if (j == 0) chk("R8 grant held", gnt_o, 7'b0000100);
      if (j > 0) begin
        chk("R3 vld", rx_vld_o, oh(VEC[j-1][2:0]));
        if (VEC[j-1][2:0] != 0) chk("R3 bit", rx_bit_o, rpat(j - 1));
        else chk("R5 no vld on unused", rx_vld_o, 0);
      end
    end
    tick(); rx_i = 0; tx_bit_i = '1;
    smp();
    chk("R3 last vld", rx_vld_o, oh(3'd3));
    chk("R3 last bit", rx_bit_o, rpat(NBIT - 1));
    chk("R6 oe idle", tx_oe_o, 0);
    chk("R6 strb idle", {rx_strb_o, tx_strb_o}, 0);
    tick(); smp();
    chk("R6 no vld idle", rx_vld_o, 0);
    chk("R6 tx quiet", tx_o, 0);

    // R9 tsync ignored while linked
    tick(); tsync_i = 1; grant_i = 0;
    tick(); tsync_i = 0;
    for (int k = 0; k < 3; k++) begin
      smp();
      chk("R9 tsync ignored oe", tx_oe_o, 0);
      chk("R9 tsync ignored gnt", gnt_o, 7'b0000100);
      tick();
    end

    // R2 bit-mode length, R9 separate sync, R8 grant=0
    wr(1, 4'd0, mk(1, 4'd2, 0, 4'd2, 3'd1));
    tick(); sync_link_i = 0; tsync_i = 1; grant_i = 0; tx_bit_i = 7'b0000001;
    smp(); chk("R1 oe before data", tx_oe_o, 0);
    for (int k = 0; k < 4; k++) begin
      tick(); tsync_i = 0; tx_bit_i = k[0] ? 7'b0000001 : 7'b1111110;
      smp();
      chk("R2 slot length", tx_oe_o, k < 3);
      chk("R2 tx data", tx_o, (k < 3) ? k[0] : 1'b0);
      chk("R9 rx not started", rx_vld_o, 0);
      if (k == 0) chk("R8 grant low", gnt_o, 0);
    end

    // R12 restart on mid-frame sync
    tick(); rsync_i = 1; rx_i = 1;
    tick(); rsync_i = 0;
    tick(); tick();
    tick(); rsync_i = 1;
    for (int j = 0; j < 11; j++) begin
      tick(); rsync_i = 0;
      smp();
      if (j == 8) chk("R12 restart vld ch2", rx_vld_o, oh(3'd2));
      if (j == 9) chk("R12 restart vld ch3", rx_vld_o, oh(3'd3));
      if (j == 10) chk("R12 restart unused", rx_vld_o, 0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule